// File: doc/BRIEF.md
# Burst Address Generator

This block keeps the address of the access in progress for a pipelined burst memory. When the controller presents an accepted address strobe, the block captures the full address and sets its burst position to zero. The two lowest bits of the captured address become the start of a four-beat burst. On each later cycle with the active-low advance input asserted, the burst position steps by one. It wraps after the fourth beat.

The low address bits are derived from the start bits and the burst position in one of two orders, chosen by a static strap. The linear order adds the position to the start bits modulo four. The interleaved order XORs the position into the start bits. The address bits above the burst field are never touched by advancing. They change only on a load.

Strobe qualification, chip-select decode and the memory array belong to the controller and are not part of this block.

Top module: `burst_addr_gen`

## Requirements
- R1: While rst_ni is low, and at once when it falls, addr_o is 0 and beat_o is 0.
- R2: At a rising edge with load_i high, the block captures addr_i. From the next cycle addr_o equals the captured address and beat_o is 0.
- R3: At a rising edge with load_i low and adv_ni low, beat_o increments by one.
- R4: At a rising edge with load_i low and adv_ni high, beat_o and addr_o keep their values (mode_i held constant). addr_i is ignored.
- R5: From any position, four advances bring beat_o back to 0 and addr_o back to the loaded address.
- R6: With mode_i = 1 (interleaved), addr_o[1:0] equals start XOR beat_o. From start 00 the low bits run 00,01,10,11. From 01 they run 01,00,11,10. From 10 they run 10,11,00,01. From 11 they run 11,10,01,00.
- R7: With mode_i = 0 (linear), addr_o[1:0] equals (start + beat_o) mod 4. For example, 01 runs 01,10,11,00. No carry reaches addr_o[2] or above.
- R8: addr_o bits above bit 1 change only at an edge with load_i high.
- R9: load_i high takes priority over adv_ni low in the same cycle. A load during a burst restarts the sequence at beat 0 from the new address.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock, rising edge active |
| rst_ni | input | 1 | Asynchronous reset, active low |
| load_i | input | 1 | Accepted address strobe: capture addr_i |
| adv_ni | input | 1 | Burst advance, active low |
| mode_i | input | 1 | Burst order strap: 1 interleaved, 0 linear |
| addr_i | input | ADDR_W (16) | Address to capture |
| addr_o | output | ADDR_W (16) | Current access address |
| beat_o | output | BEAT_W (2) | Burst position, 0 to 3 |

## Verification
The bench targets linear bursts that start at 01 and 11 and cross 11 to 00. A design that lets the increment carry would corrupt addr_o[2] and above there. It runs interleaved bursts from non-zero starts, where a design that added instead of XORing would produce a linear sequence. A strobe with advance asserted in the same cycle, and a strobe in the middle of a burst, expose any design that gives advance priority or keeps the old position. Hold cycles with a changing addr_i catch a design that tracks the input while idle. An asynchronous reset in mid-burst catches one that waits for a clock edge.

// File: rtl/burst_pkg.sv
package burst_pkg;
  typedef enum logic {
    ORDER_LINEAR      = 1'b0,
    ORDER_INTERLEAVED = 1'b1
  } order_e;
endpackage

// File: rtl/burst_base_reg.sv
module burst_base_reg #(
  parameter int ADDR_W = 16,
  parameter int BEAT_W = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic [ADDR_W-1:0] base_o
);
  logic [ADDR_W-1:0] base_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     base_q <= '0;
    else if (load_i) base_q <= addr_i;
  end

  assign base_o = base_q;

  p_load_capture_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> base_o == $past(addr_i));

  p_upper_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !load_i |=> $stable(base_o[ADDR_W-1:BEAT_W]));
endmodule

// File: rtl/burst_beat_ctr.sv
module burst_beat_ctr #(
  parameter int BEAT_W = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  input  logic              step_i,
  output logic [BEAT_W-1:0] cnt_o
);
  logic [BEAT_W-1:0] cnt_q;

  // clear wins over step
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cnt_q <= '0;
    else if (clr_i)   cnt_q <= '0;
    else if (step_i)  cnt_q <= cnt_q + 1'b1;
  end

  assign cnt_o = cnt_q;

  p_step_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clr_i && step_i && cnt_o != '1) |=> cnt_o == $past(cnt_o) + 1'b1);

  p_wrap_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clr_i && step_i && cnt_o == '1) |=> cnt_o == '0);

  p_idle_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clr_i && !step_i) |=> $stable(cnt_o));
endmodule

// File: rtl/burst_order_map.sv
module burst_order_map #(
  parameter int BEAT_W = 2
) (
  input  burst_pkg::order_e  order_i,
  input  logic [BEAT_W-1:0]  start_i,
  input  logic [BEAT_W-1:0]  beat_i,
  output logic [BEAT_W-1:0]  low_o
);
  logic [BEAT_W-1:0] lin_low;
  logic [BEAT_W-1:0] ilv_low;

  // modulo add: the sum is truncated to BEAT_W, so no carry leaves the field
  assign lin_low = start_i + beat_i;

  for (genvar b = 0; b < BEAT_W; b++) begin : g_ilv
    assign ilv_low[b] = start_i[b] ^ beat_i[b];
  end

  always_comb begin
    unique case (order_i)
      burst_pkg::ORDER_INTERLEAVED: low_o = ilv_low;
      default:                      low_o = lin_low;
    endcase
  end
endmodule

// File: rtl/burst_addr_gen.sv
module burst_addr_gen #(
  parameter int ADDR_W = 16,
  parameter int BEAT_W = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic              adv_ni,
  input  logic              mode_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic [BEAT_W-1:0] beat_o
);
  localparam int HI_W = ADDR_W - BEAT_W;

  logic [ADDR_W-1:0] base;
  logic [BEAT_W-1:0] beat;
  logic [BEAT_W-1:0] low;
  burst_pkg::order_e order;

  assign order = burst_pkg::order_e'(mode_i);

  burst_base_reg #(.ADDR_W(ADDR_W), .BEAT_W(BEAT_W)) u_base (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (load_i),
    .addr_i (addr_i),
    .base_o (base)
  );

  burst_beat_ctr #(.BEAT_W(BEAT_W)) u_ctr (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (load_i),
    .step_i (!adv_ni),
    .cnt_o  (beat)
  );

  burst_order_map #(.BEAT_W(BEAT_W)) u_map (
    .order_i (order),
    .start_i (base[BEAT_W-1:0]),
    .beat_i  (beat),
    .low_o   (low)
  );

  assign addr_o = {base[ADDR_W-1:BEAT_W], low};
  assign beat_o = beat;

  p_load_restart_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> (beat_o == '0 && addr_o[ADDR_W-1:BEAT_W] == $past(addr_i[ADDR_W-1:BEAT_W])));

  p_hold_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_i && adv_ni) |=> ($stable(beat_o) && $stable(addr_o[ADDR_W-1:BEAT_W])));

  p_reset_r1: assert property (@(posedge clk_i)
    !rst_ni |-> (addr_o == '0 && beat_o == '0));

  initial begin
    a_width_r7: assert (HI_W > 0);
  end
endmodule

// File: tb/burst_addr_gen_tb.sv
module burst_addr_gen_tb;
  localparam int ADDR_W = 16;
  localparam int BEAT_W = 2;

  logic              clk = 1'b0;
  logic              rst_ni = 1'b0;
  logic              load_i = 1'b0;
  logic              adv_ni = 1'b1;
  logic              mode_i = 1'b1;
  logic [ADDR_W-1:0] addr_i = '0;
  logic [ADDR_W-1:0] addr_o;
  logic [BEAT_W-1:0] beat_o;

  int checks = 0;
  int failures = 0;

  always #4 clk = ~clk;

  burst_addr_gen #(.ADDR_W(ADDR_W), .BEAT_W(BEAT_W)) u_dut (
    .clk_i  (clk),
    .rst_ni (rst_ni),
    .load_i (load_i),
    .adv_ni (adv_ni),
    .mode_i (mode_i),
    .addr_i (addr_i),
    .addr_o (addr_o),
    .beat_o (beat_o)
  );

  typedef struct packed {
    logic        load;
    logic        adv_n;
    logic        mode;
    logic [15:0] addr;
    logic [15:0] exp_addr;
    logic [1:0]  exp_beat;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 19;
  localparam vec_t VECS [NV] = '{
    '{1'b1, 1'b1, 1'b1, 16'h1232, 16'h1232, 2'd0, 4'd2},  // R2 load, interleaved start 10
    '{1'b0, 1'b0, 1'b1, 16'hFFFF, 16'h1233, 2'd1, 4'd6},  // R6
    '{1'b0, 1'b0, 1'b1, 16'h0000, 16'h1230, 2'd2, 4'd6},  // R6
    '{1'b0, 1'b1, 1'b1, 16'h5555, 16'h1230, 2'd2, 4'd4},  // R4 hold
    '{1'b0, 1'b0, 1'b1, 16'h0000, 16'h1231, 2'd3, 4'd6},  // R6
    '{1'b0, 1'b0, 1'b1, 16'h0000, 16'h1232, 2'd0, 4'd5},  // R5 wrap
    '{1'b1, 1'b1, 1'b0, 16'hABC5, 16'hABC5, 2'd0, 4'd2},  // R2 linear start 01
    '{1'b0, 1'b0, 1'b0, 16'h0000, 16'hABC6, 2'd1, 4'd7},  // R7
    '{1'b0, 1'b0, 1'b0, 16'h0000, 16'hABC7, 2'd2, 4'd7},  // R7
    '{1'b0, 1'b0, 1'b0, 16'h0000, 16'hABC4, 2'd3, 4'd7},  // R7 no carry
    '{1'b0, 1'b0, 1'b0, 16'h0000, 16'hABC5, 2'd0, 4'd5},  // R5
    '{1'b1, 1'b0, 1'b1, 16'h0F03, 16'h0F03, 2'd0, 4'd9},  // R9 load beats advance
    '{1'b0, 1'b0, 1'b1, 16'h0000, 16'h0F02, 2'd1, 4'd6},  // R6
    '{1'b1, 1'b1, 1'b1, 16'h7777, 16'h7777, 2'd0, 4'd9},  // R9 restart mid-burst
    '{1'b0, 1'b0, 1'b1, 16'h0000, 16'h7776, 2'd1, 4'd6},  // R6
    '{1'b0, 1'b0, 1'b1, 16'h0000, 16'h7775, 2'd2, 4'd6},  // R6
    '{1'b0, 1'b0, 1'b1, 16'h0000, 16'h7774, 2'd3, 4'd6},  // R6
    '{1'b1, 1'b1, 1'b0, 16'h00FF, 16'h00FF, 2'd0, 4'd2},  // R2 linear start 11
    '{1'b0, 1'b0, 1'b0, 16'h0000, 16'h00FC, 2'd1, 4'd8}   // R8 no carry upward
  };

  task automatic check(input string req, input logic [15:0] act_a, input logic [15:0] exp_a,
                       input logic [1:0] act_b, input logic [1:0] exp_b);
    checks++;
    if (act_a !== exp_a || act_b !== exp_b) begin
      failures++;
      $display("FAIL %s actual addr=%h beat=%0d expected addr=%h beat=%0d",
               req, act_a, act_b, exp_a, exp_b);
    end
  endtask

  task automatic finish_run();
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    failures++;
    $display("FAIL watchdog all requirements actual=hung expected=done");
    finish_run();
  end

  initial begin
    // R1 reset state
    repeat (2) @(negedge clk);
    check("R1", addr_o, 16'h0000, beat_o, 2'd0);
    rst_ni = 1'b1;

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      load_i = VECS[i].load;
      adv_ni = VECS[i].adv_n;
      mode_i = VECS[i].mode;
      addr_i = VECS[i].addr;
      @(posedge clk);
      #1;
      check($sformatf("R%0d", VECS[i].req), addr_o, VECS[i].exp_addr, beat_o, VECS[i].exp_beat);
    end

    // R4 R8: idle with changing addr_i leaves state untouched
    @(negedge clk);
    load_i = 1'b1; adv_ni = 1'b1; mode_i = 1'b0; addr_i = 16'h3C3E;
    @(negedge clk);
    load_i = 1'b0; adv_ni = 1'b0;
    @(negedge clk);
    check("R7", addr_o, 16'h3C3F, beat_o, 2'd1);
    adv_ni = 1'b1;
    for (int k = 0; k < 3; k++) begin
      addr_i = 16'h1111 * (k + 2);
      @(negedge clk);
      check("R4", addr_o, 16'h3C3F, beat_o, 2'd1);
    end
    // R5 four advances from beat 1 return to beat 1
    adv_ni = 1'b0;
    repeat (4) @(negedge clk);
    check("R5", addr_o, 16'h3C3F, beat_o, 2'd1);
    adv_ni = 1'b1;
    // R6 interleaved from start 00
    load_i = 1'b1; mode_i = 1'b1; addr_i = 16'h8000;
    @(negedge clk);
    load_i = 1'b0; adv_ni = 1'b0;
    @(negedge clk);
    check("R6", addr_o, 16'h8001, beat_o, 2'd1);
    @(negedge clk);
    check("R6", addr_o, 16'h8002, beat_o, 2'd2);
    @(negedge clk);
    check("R8", addr_o, 16'h8003, beat_o, 2'd3);
    // R1 asynchronous reset mid-burst
    #1 rst_ni = 1'b0;
    #1 check("R1", addr_o, 16'h0000, beat_o, 2'd0);
    @(negedge clk);
    check("R1", addr_o, 16'h0000, beat_o, 2'd0);
    rst_ni = 1'b1; adv_ni = 1'b1;
    @(negedge clk);
    finish_run();
  end
endmodule